// File: doc/BRIEF.md
# Address-Range Monitor and Wait-Wake Unit

This block holds the per-core state behind a monitor-then-wait instruction pair. An arm request records an address. The monitor then watches one aligned line that contains that address. The line size is a parameter, and the block reports it on an output. A store seen on the snoop port that falls in the armed line triggers the monitor.

A wait request carries a sleep-state hint and a break-on-masked-interrupt flag. If the monitor is armed and has not been triggered, the block enters a low-power wait state and shows the hint. Otherwise the wait completes at once as a no-op. While the block sleeps, a set of events can end the wait. The block then reports, for exactly one cycle, a one-hot wake cause naming the winning event. A guest-entry or guest-exit transition silently clears the monitor. Every wait, once it has ended, leaves the monitor disarmed.

The controller is a four-state machine:
- `ST_IDLE`: disarmed.
- `ST_ARMED`: armed, with no store seen.
- `ST_TRIG`: armed, and a matching store has been seen.
- `ST_SLEEP`: waiting.

It moves between those states as follows:
- The arm transition goes from IDLE, ARMED or TRIG to ARMED.
- The trigger transition goes from ARMED to TRIG.
- The sleep transition goes from ARMED to SLEEP.
- The no-op transition goes from IDLE or TRIG to IDLE. It also covers a wait in ARMED that meets a matching store in the same cycle.
- The clear transition goes from ARMED or TRIG to IDLE on a mode switch.
- The wake transition goes from SLEEP to IDLE.

Outside SLEEP, requests are handled in this priority order: mode switch, then wait, then store, then arm.

Top module: `mon_wait_unit`

## Requirements
- R1: While reset is held and right after it, `armed`, `waiting`, `noop_done` and `wake_cause` are all 0.
- R2: The output `line_bytes` equals `LINE_BYTES`. After an arm, `armed` is 1. A snooped store hits when its address shifted right by log2(`LINE_BYTES`) equals the armed address shifted the same way. No other store hits.
- R3: A wait issued while disarmed keeps `waiting` at 0 and raises `noop_done` for one cycle, in the cycle after the request.
- R4: A store hit between arm and wait makes the next wait a no-op, as in R3, and disarms the monitor.
- R5: A wait issued while armed and untriggered sets `waiting` in the next cycle. While waiting, `hint_out` equals the request's hint and holds steady. When not waiting, `hint_out` is 0.
- R6: While waiting, a store hit ends the wait with `wake_cause` = bit 0. A store outside the line leaves the block waiting.
- R7: While waiting, a pending interrupt ends the wait with `wake_cause` = bit 1 under either of two conditions. The first is that `irq_masked` is 0. The second is that both the wait's `wait_brk_irq` and `brk_irq_cap` were 1 at the wait request. In every other case the interrupt is ignored.
- R8: Each of the following ends the wait with its own `wake_cause` bit:

  | Event | `wake_cause` bit |
  |---|---|
  | debug exception | 2 |
  | NMI | 3 |
  | SMI | 4 |
  | machine check | 5 |
  | bus-init | 6 |
  | INIT | 7 |
  | architectural reset | 8 |
- R9: When several wake events arrive in the same cycle, only the highest-numbered bit is reported. `wake_cause` is always one-hot or zero.
- R10: `wake_cause` is nonzero for exactly one cycle, in the cycle after the wake event. Afterwards the monitor is disarmed, so the next wait is a no-op.
- R11: A mode switch outside the wait state disarms the monitor. A following wait is then a no-op.
- R12: Re-arming while armed or triggered replaces the watched line and clears any trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_valid | input | 1 | Arm request |
| arm_addr | input | ADDR_W | Address to monitor |
| snoop_valid | input | 1 | Observed store strobe |
| snoop_addr | input | ADDR_W | Observed store address |
| wait_valid | input | 1 | Wait request |
| wait_hint | input | HINT_W | Target sleep-state hint |
| wait_brk_irq | input | 1 | Break on masked interrupt |
| brk_irq_cap | input | 1 | Break-on-masked-interrupt supported |
| irq_pending | input | 1 | External interrupt pending |
| irq_masked | input | 1 | Interrupts masked |
| dbg_exc | input | 1 | Debug exception |
| nmi | input | 1 | Non-maskable interrupt |
| smi | input | 1 | System-management interrupt |
| mce | input | 1 | Machine check |
| binit_req | input | 1 | Bus-init event |
| init_req | input | 1 | INIT event |
| arch_reset | input | 1 | Architectural reset event |
| mode_switch | input | 1 | Guest entry or exit |
| line_bytes | output | ADDR_W+1 | Monitored line size in bytes |
| armed | output | 1 | Monitor armed |
| waiting | output | 1 | In low-power wait |
| hint_out | output | HINT_W | Active hint, 0 when not waiting |
| noop_done | output | 1 | Wait completed as no-op |
| wake_cause | output | 9 | One-hot wake cause pulse |

## Verification
The line comparison is swept over every snoop address against armed addresses at both ends and in the middle of the space. A mask placed on the wrong bits, or off by one bit, would trigger on neighbouring lines or miss the edges of the armed one.

All eight combinations of mask, break bit and capability are driven. A design that honoured the break bit without the capability would wake when it should keep sleeping.

Every pair of simultaneous wake events is applied. A reversed or broken priority encoder would report the lower event or several bits at once.

Three stale-monitor paths are tested:
- a trigger that should survive until the wait;
- a mode switch that should clear the monitor;
- a re-arm that should clear the trigger.

A design that forgets any one of them either sleeps when it should not or never sleeps.

// File: rtl/mw_pkg.sv
package mw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_TRIG  = 2'd2,
        ST_SLEEP = 2'd3
    } mw_state_e;

    localparam int EV_N     = 9;
    localparam int EV_STORE = 0;
    localparam int EV_IRQ   = 1;
    localparam int EV_DBG   = 2;
    localparam int EV_NMI   = 3;
    localparam int EV_SMI   = 4;
    localparam int EV_MCE   = 5;
    localparam int EV_BINIT = 6;
    localparam int EV_INIT  = 7;
    localparam int EV_RESET = 8;
endpackage

// File: rtl/mw_line_match.sv
module mw_line_match #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 6
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              hit
);
    logic [ADDR_W-1:0] diff;

    always_comb begin
        diff = base_addr ^ probe_addr;
        hit  = valid && ((diff >> OFS_W) == '0);
    end
endmodule

// File: rtl/mw_wake_arb.sv
module mw_wake_arb #(
    parameter int N = 9
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_slot
            if (gi == N - 1) begin : g_top
                assign grant[gi] = req[gi];
            end else begin : g_low
                assign grant[gi] = req[gi] && !(|req[N-1:gi+1]);
            end
        end
    endgenerate
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
    import mw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int HINT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_valid,
    input  logic [ADDR_W-1:0] arm_addr,
    input  logic              wait_valid,
    input  logic [HINT_W-1:0] wait_hint,
    input  logic              wait_brk_eff,
    input  logic              mode_switch,
    input  logic              snoop_hit,
    input  logic [EV_N-1:0]   wake_grant,
    output logic [ADDR_W-1:0] addr_q,
    output logic              brk_q,
    output logic              armed,
    output logic              waiting,
    output logic [HINT_W-1:0] hint_out,
    output logic              noop_done,
    output logic [EV_N-1:0]   wake_cause
);
    mw_state_e         state, nxt;
    logic [ADDR_W-1:0] addr_d;
    logic [HINT_W-1:0] hint_q, hint_d;
    logic              brk_d, noop_d;
    logic [EV_N-1:0]   wake_d;

    // next-state process
    always_comb begin
        nxt    = state;
        addr_d = addr_q;
        hint_d = hint_q;
        brk_d  = brk_q;
        noop_d = 1'b0;
        wake_d = '0;
        unique case (state)
            ST_IDLE: begin
                if (mode_switch) begin
                    nxt = ST_IDLE;
                end else if (wait_valid) begin
                    noop_d = 1'b1;
                end else if (arm_valid) begin
                    nxt    = ST_ARMED;
                    addr_d = arm_addr;
                end
            end
            ST_ARMED: begin
                if (mode_switch) begin
                    nxt = ST_IDLE;
                end else if (wait_valid) begin
                    if (snoop_hit) begin
                        noop_d = 1'b1;
                        nxt    = ST_IDLE;
                    end else begin
                        nxt    = ST_SLEEP;
                        hint_d = wait_hint;
                        brk_d  = wait_brk_eff;
                    end
                end else if (snoop_hit) begin
                    nxt = ST_TRIG;
                end else if (arm_valid) begin
                    addr_d = arm_addr;
                end
            end
            ST_TRIG: begin
                if (mode_switch) begin
                    nxt = ST_IDLE;
                end else if (wait_valid) begin
                    noop_d = 1'b1;
                    nxt    = ST_IDLE;
                end else if (arm_valid) begin
                    nxt    = ST_ARMED;
                    addr_d = arm_addr;
                end
            end
            ST_SLEEP: begin
                if (|wake_grant) begin
                    wake_d = wake_grant;
                    nxt    = ST_IDLE;
                    brk_d  = 1'b0;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            addr_q     <= '0;
            hint_q     <= '0;
            brk_q      <= 1'b0;
            noop_done  <= 1'b0;
            wake_cause <= '0;
        end else begin
            state      <= nxt;
            addr_q     <= addr_d;
            hint_q     <= hint_d;
            brk_q      <= brk_d;
            noop_done  <= noop_d;
            wake_cause <= wake_d;
        end
    end

    // output process
    always_comb begin
        armed    = (state == ST_ARMED) || (state == ST_TRIG);
        waiting  = (state == ST_SLEEP);
        hint_out = waiting ? hint_q : '0;
    end

    assert_noop_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wait_valid && !mode_switch) |=> (noop_done && !waiting));

    assert_noop_trig_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRIG && wait_valid && !mode_switch) |=> (noop_done && !armed && !waiting));

    assert_hint_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && $past(waiting)) |-> $stable(hint_out));

    assert_wake_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wake_cause));

    assert_wake_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|wake_cause) |-> ($past(waiting) && !waiting && !armed));

    assert_mode_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_switch && !waiting) |=> !armed);
endmodule

// File: rtl/mon_wait_unit.sv
module mon_wait_unit
    import mw_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 64,
    parameter int HINT_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_valid,
    input  logic [ADDR_W-1:0] arm_addr,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              wait_valid,
    input  logic [HINT_W-1:0] wait_hint,
    input  logic              wait_brk_irq,
    input  logic              brk_irq_cap,
    input  logic              irq_pending,
    input  logic              irq_masked,
    input  logic              dbg_exc,
    input  logic              nmi,
    input  logic              smi,
    input  logic              mce,
    input  logic              binit_req,
    input  logic              init_req,
    input  logic              arch_reset,
    input  logic              mode_switch,
    output logic [ADDR_W:0]   line_bytes,
    output logic              armed,
    output logic              waiting,
    output logic [HINT_W-1:0] hint_out,
    output logic              noop_done,
    output logic [EV_N-1:0]   wake_cause
);
    localparam int OFS_W = $clog2(LINE_BYTES);

    logic [ADDR_W-1:0] addr_q;
    logic              brk_q;
    logic              snoop_hit;
    logic [EV_N-1:0]   ev_req, ev_grant;

    assign line_bytes = (ADDR_W + 1)'(LINE_BYTES);

    mw_line_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_match (
        .valid      (snoop_valid),
        .base_addr  (addr_q),
        .probe_addr (snoop_addr),
        .hit        (snoop_hit)
    );

    always_comb begin
        ev_req            = '0;
        ev_req[EV_STORE]  = snoop_hit;
        ev_req[EV_IRQ]    = irq_pending && (!irq_masked || brk_q);
        ev_req[EV_DBG]    = dbg_exc;
        ev_req[EV_NMI]    = nmi;
        ev_req[EV_SMI]    = smi;
        ev_req[EV_MCE]    = mce;
        ev_req[EV_BINIT]  = binit_req;
        ev_req[EV_INIT]   = init_req;
        ev_req[EV_RESET]  = arch_reset;
    end

    mw_wake_arb #(.N(EV_N)) i_arb (
        .req   (ev_req),
        .grant (ev_grant)
    );

    mw_ctrl #(.ADDR_W(ADDR_W), .HINT_W(HINT_W)) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm_valid    (arm_valid),
        .arm_addr     (arm_addr),
        .wait_valid   (wait_valid),
        .wait_hint    (wait_hint),
        .wait_brk_eff (wait_brk_irq && brk_irq_cap),
        .mode_switch  (mode_switch),
        .snoop_hit    (snoop_hit),
        .wake_grant   (ev_grant),
        .addr_q       (addr_q),
        .brk_q        (brk_q),
        .armed        (armed),
        .waiting      (waiting),
        .hint_out     (hint_out),
        .noop_done    (noop_done),
        .wake_cause   (wake_cause)
    );

    assert_reset_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && arch_reset) |=> (wake_cause[EV_RESET] && $onehot(wake_cause)));

    assert_masked_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !brk_q && irq_pending && irq_masked && !snoop_valid && !dbg_exc && !nmi
         && !smi && !mce && !binit_req && !init_req && !arch_reset) |=> waiting);
endmodule

// File: tb/test_mon_wait_unit.sv
module test_mon_wait_unit;
    localparam int AW = 8;
    localparam int LB = 16;
    localparam int HW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm_valid = 0, snoop_valid = 0, wait_valid = 0, wait_brk_irq = 0;
    logic          brk_irq_cap = 0, irq_pending = 0, irq_masked = 0, dbg_exc = 0, nmi = 0;
    logic          smi = 0, mce = 0, binit_req = 0, init_req = 0, arch_reset = 0, mode_switch = 0;
    logic [AW-1:0] arm_addr = '0, snoop_addr = '0;
    logic [HW-1:0] wait_hint = '0;
    logic [AW:0]   line_bytes;
    logic          armed, waiting, noop_done;
    logic [HW-1:0] hint_out;
    logic [8:0]    wake_cause;

    int chk = 0;
    int bad = 0;

    always #4 clk = ~clk;

    mon_wait_unit #(.ADDR_W(AW), .LINE_BYTES(LB), .HINT_W(HW)) i_mon_wait_unit (
        .clk(clk), .rst_n(rst_n), .arm_valid(arm_valid), .arm_addr(arm_addr),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .wait_valid(wait_valid),
        .wait_hint(wait_hint), .wait_brk_irq(wait_brk_irq), .brk_irq_cap(brk_irq_cap),
        .irq_pending(irq_pending), .irq_masked(irq_masked), .dbg_exc(dbg_exc), .nmi(nmi),
        .smi(smi), .mce(mce), .binit_req(binit_req), .init_req(init_req),
        .arch_reset(arch_reset), .mode_switch(mode_switch), .line_bytes(line_bytes),
        .armed(armed), .waiting(waiting), .hint_out(hint_out), .noop_done(noop_done),
        .wake_cause(wake_cause)
    );

    task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_arm(input logic [AW-1:0] a);
        arm_valid = 1; arm_addr = a; step(); arm_valid = 0;
    endtask

    task automatic do_snoop(input logic [AW-1:0] a);
        snoop_valid = 1; snoop_addr = a; step(); snoop_valid = 0;
    endtask

    task automatic do_wait(input logic [HW-1:0] h, input logic b);
        wait_valid = 1; wait_hint = h; wait_brk_irq = b; step();
        wait_valid = 0; wait_brk_irq = 0;
    endtask

    task automatic kick_out();
        if (waiting) begin
            nmi = 1; step(); nmi = 0;
        end
        step();
    endtask

    task automatic drive_ev(input logic [8:0] v, input logic [AW-1:0] a);
        snoop_valid = v[0]; snoop_addr = a; irq_pending = v[1]; dbg_exc = v[2];
        nmi = v[3]; smi = v[4]; mce = v[5]; binit_req = v[6]; init_req = v[7];
        arch_reset = v[8];
    endtask

    initial begin
        #(8 * 200000);
        chk++; bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", chk - bad, chk);
        $finish;
    end

    initial begin
        logic hit;
        logic exp_wake;
        logic [7:0] bases [3];
        bases[0] = 8'h00; bases[1] = 8'h35; bases[2] = 8'hFF;

        // R1 reset state
        step(); step();
        expect_eq("R1 armed", armed, 0);
        expect_eq("R1 waiting", waiting, 0);
        expect_eq("R1 wake", wake_cause, 0);
        expect_eq("R1 noop", noop_done, 0);
        rst_n = 1; step();
        expect_eq("R1 armed after", armed, 0);
        expect_eq("R2 line_bytes", line_bytes, LB);

        // R3 wait while disarmed
        do_wait(4'h3, 0);
        expect_eq("R3 noop", noop_done, 1);
        expect_eq("R3 waiting", waiting, 0);
        step();
        expect_eq("R3 noop pulse", noop_done, 0);

        // R2/R4 line sweep between arm and wait
        for (int bi = 0; bi < 3; bi++) begin
            for (int s = 0; s < 256; s++) begin
                do_arm(bases[bi]);
                expect_eq("R2 armed", armed, 1);
                do_snoop(s[7:0]);
                hit = (s[7:4] == bases[bi][7:4]);
                do_wait(0, 0);
                expect_eq("R4 noop on trigger", noop_done, hit);
                expect_eq("R2 sleep if no hit", waiting, !hit);
                if (hit) expect_eq("R4 disarmed", armed, 0);
                kick_out();
            end
        end

        // R6 store during sleep
        for (int s = 0; s < 256; s++) begin
            do_arm(8'h35);
            do_wait(0, 0);
            hit = (s[7:4] == 4'h3);
            do_snoop(s[7:0]);
            expect_eq("R6 store wake", wake_cause, hit ? 9'h001 : 9'h000);
            expect_eq("R6 still waiting", waiting, !hit);
            kick_out();
        end

        // R7 interrupt gating
        for (int c = 0; c < 8; c++) begin
            irq_masked = c[0]; brk_irq_cap = c[2];
            do_arm(8'h10);
            do_wait(0, c[1]);
            exp_wake = !c[0] || (c[1] && c[2]);
            irq_pending = 1; step(); irq_pending = 0;
            expect_eq("R7 irq wake", wake_cause, exp_wake ? 9'h002 : 9'h000);
            expect_eq("R7 waiting", waiting, !exp_wake);
            kick_out();
        end
        irq_masked = 0; brk_irq_cap = 0;

        // R8/R10 each event
        for (int b = 1; b < 9; b++) begin
            do_arm(8'h35);
            do_wait(0, 0);
            drive_ev(9'(1) << b, 8'h00); step(); drive_ev('0, 8'h00);
            expect_eq("R8 event cause", wake_cause, 9'(1) << b);
            expect_eq("R8 left wait", waiting, 0);
            step();
            expect_eq("R10 pulse one cycle", wake_cause, 0);
            do_wait(0, 0);
            expect_eq("R10 disarmed after wake", noop_done, 1);
        end

        // R9 pairwise priority
        for (int i = 0; i < 9; i++) begin
            for (int j = i + 1; j < 9; j++) begin
                do_arm(8'h35);
                do_wait(0, 0);
                drive_ev((9'(1) << i) | (9'(1) << j), 8'h3A); step(); drive_ev('0, 8'h00);
                expect_eq("R9 priority", wake_cause, 9'(1) << j);
                step();
            end
        end

        // R5 hint sweep
        for (int h = 0; h < 16; h++) begin
            do_arm(8'h40);
            expect_eq("R5 hint idle", hint_out, 0);
            do_wait(h[3:0], 0);
            expect_eq("R5 waiting", waiting, 1);
            expect_eq("R5 hint", hint_out, h);
            step();
            expect_eq("R5 hint hold", hint_out, h);
            kick_out();
            expect_eq("R5 hint cleared", hint_out, 0);
        end

        // R11 mode switch
        do_arm(8'h20);
        mode_switch = 1; step(); mode_switch = 0;
        expect_eq("R11 disarmed", armed, 0);
        do_wait(0, 0);
        expect_eq("R11 noop", noop_done, 1);
        do_arm(8'h20); do_snoop(8'h21);
        mode_switch = 1; step(); mode_switch = 0;
        expect_eq("R11 disarmed trig", armed, 0);
        step();

        // R12 re-arm clears trigger and moves line
        do_arm(8'h35);
        do_snoop(8'h30);
        do_arm(8'h80);
        expect_eq("R12 armed", armed, 1);
        do_wait(0, 0);
        expect_eq("R12 sleeps", waiting, 1);
        do_snoop(8'h3F);
        expect_eq("R12 old line ignored", waiting, 1);
        do_snoop(8'h8A);
        expect_eq("R12 new line wakes", wake_cause, 9'h001);
        step();

        $display("%0d/%0d checks passed", chk - bad, chk);
        $finish;
    end
endmodule